// File: doc/BRIEF.md
# Gated Preload Register Update Controller

This block keeps two copies of a timer's compare and period registers. The active copy drives the timer. The shadow (preload) copy collects bus writes. A preload-enable bit picks the target of each write. When it is clear, a write lands in the active copy at once. When it is set, the write lands in the shadow copy and reaches the active copy only on a transfer.

A 4-bit gating mode sets when a transfer happens. It can happen on any enabled update event, on the end of a DMA burst, or on a rising edge of one of three external update-enable inputs. The burst end or the edge can also act as an arming condition: the transfer then waits for the next enabled update event. An enable mask chooses which sources count as update events: the master timer, peer timers, and the timer's own reset and repetition events. The mask entry for the timer's own index is ignored. Each transfer gives a one-cycle transfer pulse. It can also pulse one of three DAC synchronisation outputs.

The gating mode can only move from zero to a non-zero value, or from any value back to zero. A write that tries to move it directly between two non-zero values is dropped.

Top module: `preload_gate_ctrl`

## Requirements
- R1: After reset, every active and shadow register holds zero, `gate_mode` is 0, and `xfer_pulse` and `dac_trg` are low.
- R2: With preload disabled, a bus write appears in the addressed active register on the next cycle, and the shadow register is left unchanged.
- R3: With preload enabled, a bus write changes only the shadow register. The active copy stays stable unless a transfer occurs.
- R4: Mode 0 transfers on every enabled update event, one cycle later on `xfer_pulse`. A burst end or an enable edge on its own causes no transfer in this mode.
- R5: An update event counts only when its enable bit is set. The peer enable and peer event at index SELF_IDX never count.
- R6: Mode 1 transfers on a burst end and also on any enabled update event, so a burst end followed by an event gives two transfers.
- R7: Mode 2 transfers only on the first enabled update event in a cycle after a burst end. An event with no earlier burst end, or a burst end alone, gives no transfer.
- R8: Modes 3, 4 and 5 transfer on a rising edge of `upd_en_in[0]`, `[1]` and `[2]` respectively, and also on enabled update events. An input held high gives only one transfer, and the other inputs' edges are ignored.
- R9: Modes 6, 7 and 8 transfer on the first enabled update event after a rising edge of `upd_en_in[0]`, `[1]` and `[2]` respectively. An edge alone, or an edge on a different input, gives no transfer.
- R10: Gating codes 9 to 15 never cause a transfer.
- R11: A config write that would change `gate_mode` from one non-zero value straight to another non-zero value leaves the old mode in place. Writing 0 first makes the new value take effect.
- R12: Each transfer raises `xfer_pulse` for one cycle. The DAC select code chooses the output that pulses in the same cycle: 00 pulses none, 01 pulses `dac_trg[0]`, 10 pulses `dac_trg[1]`, 11 pulses `dac_trg[2]`.
- R13: If a shadow write and a transfer fall in the same cycle, the active register receives the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Config register write strobe |
| cfg_gate_in | input | 4 | New gating mode |
| cfg_preload_in | input | 1 | New preload enable |
| cfg_dac_in | input | 2 | New DAC select code |
| cfg_master_en_in | input | 1 | New master update enable |
| cfg_peer_en_in | input | NUM_PEERS | New peer update enables |
| cfg_rst_en_in | input | 1 | New own-reset event enable |
| cfg_rep_en_in | input | 1 | New own-repetition event enable |
| master_upd | input | 1 | Master timer update event |
| peer_upd | input | NUM_PEERS | Peer timer update events |
| own_rst_evt | input | 1 | Own counter reset event |
| own_rep_evt | input | 1 | Own repetition event |
| burst_done | input | 1 | DMA burst completion pulse |
| upd_en_in | input | 3 | External update-enable inputs |
| wr_en | input | 1 | Bus register write strobe |
| wr_addr | input | $clog2(NUM_REGS) | Register index |
| wr_data | input | DATA_W | Write data |
| gate_mode | output | 4 | Gating mode in effect |
| active_flat | output | NUM_REGS*DATA_W | Active registers, index 0 in the low bits |
| preload_flat | output | NUM_REGS*DATA_W | Shadow registers, index 0 in the low bits |
| xfer_pulse | output | 1 | One-cycle transfer pulse |
| dac_trg | output | 3 | DAC synchronisation pulses |

## Verification
The bench builds the block with DATA_W=16, NUM_REGS=4 and NUM_PEERS=6. It sets SELF_IDX to 2 rather than the default 0, so the masking of the block's own index is tested at a position inside the peer vector, with live peer bits on both sides of it. Four registers let the bench check that a direct write to index 1 leaves the index 0 register untouched while the gating tests run on index 0. A 16-bit width leaves room for a distinct value in every test vector.

// File: rtl/pgu_pkg.sv
package pgu_pkg;

    localparam int NUM_EDGE_IN = 3;

    typedef enum logic [3:0] {
        GATE_FREE          = 4'd0,
        GATE_BURST         = 4'd1,
        GATE_BURST_THEN_EV = 4'd2,
        GATE_EDGE_A        = 4'd3,
        GATE_EDGE_B        = 4'd4,
        GATE_EDGE_C        = 4'd5,
        GATE_EDGE_A_THEN   = 4'd6,
        GATE_EDGE_B_THEN   = 4'd7,
        GATE_EDGE_C_THEN   = 4'd8
    } gate_mode_e;

    typedef struct packed {
        logic [3:0] gate;
        logic       preload_en;
        logic [1:0] dac_sel;
        logic       master_en;
        logic       rst_en;
        logic       rep_en;
    } cfg_t;

    function automatic logic gate_reserved(input logic [3:0] m);
        return m > GATE_EDGE_C_THEN;
    endfunction

    function automatic logic [1:0] edge_index(input logic [3:0] m);
        logic [3:0] d;
        if (m >= GATE_EDGE_A_THEN) d = m - 4'(GATE_EDGE_A_THEN);
        else                       d = m - 4'(GATE_EDGE_A);
        return d[1:0];
    endfunction

    function automatic logic [NUM_EDGE_IN-1:0] dac_decode(input logic [1:0] sel);
        logic [NUM_EDGE_IN-1:0] r;
        r = '0;
        if (sel != 2'b00) r[sel - 2'd1] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pgu_edge_detect.sv
module pgu_edge_detect #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] din_q;

    always_ff @(posedge clk) begin
        if (rst) din_q <= '0;
        else     din_q <= din;
    end

    assign rise = din & ~din_q;
endmodule

// File: rtl/pgu_event_merge.sv
module pgu_event_merge #(
    parameter int NUM_PEERS = 6,
    parameter int SELF_IDX  = 0
) (
    input  logic                 master_en,
    input  logic                 master_upd,
    input  logic [NUM_PEERS-1:0] peer_en,
    input  logic [NUM_PEERS-1:0] peer_upd,
    input  logic                 rst_en,
    input  logic                 own_rst_evt,
    input  logic                 rep_en,
    input  logic                 own_rep_evt,
    output logic                 evt_any
);
    logic [NUM_PEERS-1:0] peer_mask;
    logic [NUM_PEERS-1:0] peer_hit;

    for (genvar i = 0; i < NUM_PEERS; i++) begin : g_peer
        if (i == SELF_IDX) begin : g_self
            assign peer_mask[i] = 1'b0;
        end else begin : g_other
            assign peer_mask[i] = 1'b1;
        end
    end

    assign peer_hit = peer_en & peer_upd & peer_mask;

    assign evt_any = (master_en & master_upd)
                   | (|peer_hit)
                   | (rst_en & own_rst_evt)
                   | (rep_en & own_rep_evt);
endmodule

// File: rtl/pgu_gate_ctrl.sv
module pgu_gate_ctrl
    import pgu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             gate_mode,
    input  logic                   evt_any,
    input  logic                   burst_done,
    input  logic [NUM_EDGE_IN-1:0] rise,
    output logic                   do_xfer
);
    logic [3:0] mode_q;
    logic       pending_q;
    logic       pending_d;
    logic       arm;
    logic       changed;
    logic       sel_rise;

    assign changed  = (gate_mode != mode_q);
    assign sel_rise = rise[edge_index(gate_mode)];

    always_comb begin
        do_xfer = 1'b0;
        arm     = 1'b0;
        if (!gate_reserved(gate_mode)) begin
            case (gate_mode)
                GATE_FREE:          do_xfer = evt_any;
                GATE_BURST:         do_xfer = evt_any | burst_done;
                GATE_BURST_THEN_EV: begin
                    do_xfer = evt_any & pending_q & ~changed;
                    arm     = burst_done;
                end
                GATE_EDGE_A, GATE_EDGE_B, GATE_EDGE_C:
                    do_xfer = evt_any | sel_rise;
                default: begin
                    do_xfer = evt_any & pending_q & ~changed;
                    arm     = sel_rise;
                end
            endcase
        end
    end

    always_comb begin
        if (changed) pending_d = 1'b0;
        else         pending_d = (pending_q & ~do_xfer) | arm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            pending_q <= 1'b0;
        end else begin
            mode_q    <= gate_mode;
            pending_q <= pending_d;
        end
    end
endmodule

// File: rtl/pgu_reg_bank.sv
module pgu_reg_bank #(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       preload_en,
    input  logic                       do_xfer,
    output logic [NUM_REGS*DATA_W-1:0] active_flat,
    output logic [NUM_REGS*DATA_W-1:0] preload_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        logic [DATA_W-1:0] pre_q;
        logic [DATA_W-1:0] act_q;
        logic [DATA_W-1:0] pre_nx;
        logic              hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(i));

        always_comb begin
            if (hit && preload_en) pre_nx = wr_data;
            else                   pre_nx = pre_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                pre_q <= '0;
                act_q <= '0;
            end else begin
                pre_q <= pre_nx;
                if (hit && !preload_en) act_q <= wr_data;
                else if (do_xfer)       act_q <= pre_nx;
            end
        end

        assign active_flat[i*DATA_W +: DATA_W]  = act_q;
        assign preload_flat[i*DATA_W +: DATA_W] = pre_q;
    end
endmodule

// File: rtl/preload_gate_ctrl.sv
module preload_gate_ctrl
    import pgu_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_REGS  = 4,
    parameter int NUM_PEERS = 6,
    parameter int SELF_IDX  = 0,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr,
    input  logic [3:0]                 cfg_gate_in,
    input  logic                       cfg_preload_in,
    input  logic [1:0]                 cfg_dac_in,
    input  logic                       cfg_master_en_in,
    input  logic [NUM_PEERS-1:0]       cfg_peer_en_in,
    input  logic                       cfg_rst_en_in,
    input  logic                       cfg_rep_en_in,
    input  logic                       master_upd,
    input  logic [NUM_PEERS-1:0]       peer_upd,
    input  logic                       own_rst_evt,
    input  logic                       own_rep_evt,
    input  logic                       burst_done,
    input  logic [NUM_EDGE_IN-1:0]     upd_en_in,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [3:0]                 gate_mode,
    output logic [NUM_REGS*DATA_W-1:0] active_flat,
    output logic [NUM_REGS*DATA_W-1:0] preload_flat,
    output logic                       xfer_pulse,
    output logic [NUM_EDGE_IN-1:0]     dac_trg
);
    cfg_t                   cfg_q;
    logic [NUM_PEERS-1:0]   peer_en_q;
    logic [NUM_EDGE_IN-1:0] rise;
    logic                   evt_any;
    logic                   do_xfer;
    logic                   preload_en_w;
    logic                   xfer_q;
    logic [NUM_EDGE_IN-1:0] dac_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            peer_en_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.preload_en <= cfg_preload_in;
            cfg_q.dac_sel    <= cfg_dac_in;
            cfg_q.master_en  <= cfg_master_en_in;
            cfg_q.rst_en     <= cfg_rst_en_in;
            cfg_q.rep_en     <= cfg_rep_en_in;
            peer_en_q        <= cfg_peer_en_in;
            if (cfg_q.gate == 4'd0 || cfg_gate_in == 4'd0)
                cfg_q.gate <= cfg_gate_in;
        end
    end

    assign gate_mode    = cfg_q.gate;
    assign preload_en_w = cfg_q.preload_en;

    pgu_edge_detect #(.WIDTH(NUM_EDGE_IN)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (upd_en_in),
        .rise (rise)
    );

    pgu_event_merge #(.NUM_PEERS(NUM_PEERS), .SELF_IDX(SELF_IDX)) u_evt (
        .master_en   (cfg_q.master_en),
        .master_upd  (master_upd),
        .peer_en     (peer_en_q),
        .peer_upd    (peer_upd),
        .rst_en      (cfg_q.rst_en),
        .own_rst_evt (own_rst_evt),
        .rep_en      (cfg_q.rep_en),
        .own_rep_evt (own_rep_evt),
        .evt_any     (evt_any)
    );

    pgu_gate_ctrl u_gate (
        .clk        (clk),
        .rst        (rst),
        .gate_mode  (cfg_q.gate),
        .evt_any    (evt_any),
        .burst_done (burst_done),
        .rise       (rise),
        .do_xfer    (do_xfer)
    );

    pgu_reg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .preload_en   (preload_en_w),
        .do_xfer      (do_xfer),
        .active_flat  (active_flat),
        .preload_flat (preload_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= 1'b0;
            dac_q  <= '0;
        end else begin
            xfer_q <= do_xfer;
            dac_q  <= do_xfer ? dac_decode(cfg_q.dac_sel) : '0;
        end
    end

    assign xfer_pulse = xfer_q;
    assign dac_trg    = dac_q;
endmodule

// File: rtl/pgu_checker.sv
module pgu_checker #(
    parameter int ACT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       gate_mode,
    input logic             evt_any,
    input logic             xfer_pulse,
    input logic [2:0]       dac_trg,
    input logic             preload_en,
    input logic             cfg_wr,
    input logic [3:0]       cfg_gate_in,
    input logic [ACT_W-1:0] active_flat
);
    // R12
    dac_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dac_trg));

    // R12
    dac_with_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_trg != 3'b000) |-> xfer_pulse);

    // R10
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && gate_mode > 4'd8) |-> !xfer_pulse);

    // R11
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && cfg_wr && gate_mode != 4'd0 && cfg_gate_in != 4'd0)
        |-> (gate_mode == $past(gate_mode)));

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && preload_en) && !xfer_pulse) |-> $stable(active_flat));

    // R4
    free_mode_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && gate_mode == 4'd0 && evt_any) |-> xfer_pulse);
endmodule

bind preload_gate_ctrl pgu_checker #(.ACT_W(NUM_REGS*DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gate_mode   (gate_mode),
    .evt_any     (evt_any),
    .xfer_pulse  (xfer_pulse),
    .dac_trg     (dac_trg),
    .preload_en  (preload_en_w),
    .cfg_wr      (cfg_wr),
    .cfg_gate_in (cfg_gate_in),
    .active_flat (active_flat)
);

// File: tb/sim_preload_gate_ctrl.sv
`timescale 1ns/1ps
module sim_preload_gate_ctrl;
    localparam int DW = 16;
    localparam int NR = 4;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 0;
    logic [3:0]    cfg_gate_in = 0;
    logic          cfg_preload_in = 0;
    logic [1:0]    cfg_dac_in = 0;
    logic          cfg_master_en_in = 0;
    logic [NP-1:0] cfg_peer_en_in = 0;
    logic          cfg_rst_en_in = 0;
    logic          cfg_rep_en_in = 0;
    logic          master_upd = 0;
    logic [NP-1:0] peer_upd = 0;
    logic          own_rst_evt = 0;
    logic          own_rep_evt = 0;
    logic          burst_done = 0;
    logic [2:0]    upd_en_in = 0;
    logic          wr_en = 0;
    logic [1:0]    wr_addr = 0;
    logic [DW-1:0] wr_data = 0;
    logic [3:0]    gate_mode;
    logic [NR*DW-1:0] active_flat;
    logic [NR*DW-1:0] preload_flat;
    logic          xfer_pulse;
    logic [2:0]    dac_trg;

    int checks = 0;
    int errors = 0;
    int xcnt   = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    preload_gate_ctrl #(.DATA_W(DW), .NUM_REGS(NR), .NUM_PEERS(NP), .SELF_IDX(2)) u0 (.*);

    always @(negedge clk) if (!rst && xfer_pulse) xcnt = xcnt + 1;

    // vector: mode[10:7], kind[6:4], input index[3:2], expected transfers[1:0]
    // kind 0 event, 1 burst, 2 burst then event, 3 edge, 4 edge then event
    localparam int NV = 21;
    localparam logic [10:0] VEC [NV] = '{
        {4'd0, 3'd0, 2'd0, 2'd1}, {4'd0, 3'd1, 2'd0, 2'd0}, {4'd0, 3'd3, 2'd0, 2'd0},
        {4'd1, 3'd1, 2'd0, 2'd1}, {4'd1, 3'd0, 2'd0, 2'd1}, {4'd1, 3'd2, 2'd0, 2'd2},
        {4'd2, 3'd0, 2'd0, 2'd0}, {4'd2, 3'd1, 2'd0, 2'd0}, {4'd2, 3'd2, 2'd0, 2'd1},
        {4'd3, 3'd3, 2'd0, 2'd1}, {4'd3, 3'd3, 2'd1, 2'd0}, {4'd4, 3'd3, 2'd1, 2'd1},
        {4'd5, 3'd3, 2'd2, 2'd1}, {4'd5, 3'd0, 2'd0, 2'd1}, {4'd6, 3'd3, 2'd0, 2'd0},
        {4'd6, 3'd4, 2'd0, 2'd1}, {4'd7, 3'd4, 2'd1, 2'd1}, {4'd7, 3'd4, 2'd0, 2'd0},
        {4'd8, 3'd4, 2'd2, 2'd1}, {4'd9, 3'd0, 2'd0, 2'd0}, {4'd15, 3'd2, 2'd0, 2'd0}
    };

    function automatic string req_of(input logic [3:0] m);
        if (m == 0) return "R4";
        if (m == 1) return "R6";
        if (m == 2) return "R7";
        if (m <= 5) return "R8";
        if (m <= 8) return "R9";
        return "R10";
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] g, input logic pre, input logic [1:0] dac,
                       input logic m, input logic [NP-1:0] peers, input logic r, input logic rp);
        @(negedge clk);
        cfg_wr = 1; cfg_gate_in = g; cfg_preload_in = pre; cfg_dac_in = dac;
        cfg_master_en_in = m; cfg_peer_en_in = peers; cfg_rst_en_in = r; cfg_rep_en_in = rp;
        @(negedge clk);
        cfg_wr = 0;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic stim(input logic [2:0] kind, input logic [1:0] k);
        @(negedge clk);
        case (kind)
            3'd0: master_upd = 1;
            3'd1, 3'd2: burst_done = 1;
            default: upd_en_in[k] = 1;
        endcase
        @(negedge clk);
        burst_done = 0; upd_en_in = 0; master_upd = 0;
        if (kind == 3'd2 || kind == 3'd4) begin
            master_upd = 1;
            @(negedge clk);
            master_upd = 0;
        end
    endtask

    initial begin
        logic [DW-1:0] exp_a0;
        exp_a0 = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(gate_mode == 0, "R1", 64'(gate_mode), 0);
        chk(active_flat == 0 && preload_flat == 0, "R1", active_flat, 0);
        chk(!xfer_pulse && dac_trg == 0, "R1", {xfer_pulse, dac_trg}, 0);
        rst = 0;

        // R2 direct write with preload disabled
        cfg(0, 0, 0, 0, 0, 0, 0);
        bus_write(2'd1, 16'hAAAA);
        chk(active_flat[31:16] == 16'hAAAA, "R2", 64'(active_flat[31:16]), 64'hAAAA);
        chk(preload_flat[31:16] == 0, "R2", 64'(preload_flat[31:16]), 0);

        // R3 shadow write does not touch active
        cfg(0, 1, 1, 1, 0, 0, 0);
        bus_write(2'd1, 16'h5555);
        repeat (2) @(negedge clk);
        chk(active_flat[31:16] == 16'hAAAA, "R3", 64'(active_flat[31:16]), 64'hAAAA);
        chk(preload_flat[31:16] == 16'h5555, "R3", 64'(preload_flat[31:16]), 64'h5555);
        stim(3'd0, 2'd0);
        repeat (2) @(negedge clk);
        chk(active_flat[31:16] == 16'h5555, "R3", 64'(active_flat[31:16]), 64'h5555);
        exp_a0 = active_flat[15:0];

        // table walk over the gating modes
        for (int i = 0; i < NV; i++) begin
            logic [3:0] m;
            logic [DW-1:0] v;
            m = VEC[i][10:7];
            v = DW'(16'h1000 + i);
            cfg(0, 1, 1, 1, 0, 0, 0);
            cfg(m, 1, 1, 1, 0, 0, 0);
            bus_write(2'd0, v);
            @(negedge clk);
            xcnt = 0;
            stim(VEC[i][6:4], VEC[i][3:2]);
            repeat (3) @(negedge clk);
            if (VEC[i][1:0] != 0) exp_a0 = v;
            chk(xcnt == int'(VEC[i][1:0]), req_of(m), 64'(xcnt), 64'(VEC[i][1:0]));
            chk(active_flat[15:0] == exp_a0, req_of(m), 64'(active_flat[15:0]), 64'(exp_a0));
        end

        // R5 event mask and own-index peer ignored
        cfg(0, 1, 0, 0, 6'b111111, 0, 1);
        @(negedge clk); xcnt = 0; peer_upd[2] = 1;
        @(negedge clk); peer_upd = 0; repeat (2) @(negedge clk);
        chk(xcnt == 0, "R5", 64'(xcnt), 0);
        xcnt = 0; master_upd = 1; own_rst_evt = 1;
        @(negedge clk); master_upd = 0; own_rst_evt = 0; repeat (2) @(negedge clk);
        chk(xcnt == 0, "R5", 64'(xcnt), 0);
        xcnt = 0; peer_upd[3] = 1;
        @(negedge clk); peer_upd = 0; own_rep_evt = 1;
        @(negedge clk); own_rep_evt = 0; repeat (2) @(negedge clk);
        chk(xcnt == 2, "R5", 64'(xcnt), 2);

        // R8 held input gives one transfer
        cfg(0, 1, 0, 0, 0, 0, 0);
        cfg(3, 1, 0, 0, 0, 0, 0);
        xcnt = 0; upd_en_in[0] = 1;
        repeat (5) @(negedge clk);
        upd_en_in = 0; repeat (2) @(negedge clk);
        chk(xcnt == 1, "R8", 64'(xcnt), 1);

        // R11 direct non-zero overwrite dropped
        cfg(6, 1, 0, 0, 0, 0, 0);
        chk(gate_mode == 3, "R11", 64'(gate_mode), 3);
        cfg(0, 1, 0, 0, 0, 0, 0);
        cfg(6, 1, 0, 0, 0, 0, 0);
        chk(gate_mode == 6, "R11", 64'(gate_mode), 6);

        // R12 DAC select and single-cycle pulse
        for (int s = 0; s < 4; s++) begin
            logic [2:0] e;
            e = (s == 0) ? 3'b000 : 3'(1 << (s - 1));
            cfg(0, 1, 2'(s), 1, 0, 0, 0);
            @(negedge clk); master_upd = 1;
            @(negedge clk);
            chk(xfer_pulse && dac_trg == e, "R12", {xfer_pulse, dac_trg}, {1'b1, e});
            master_upd = 0;
            @(negedge clk);
            chk(!xfer_pulse && dac_trg == 0, "R12", {xfer_pulse, dac_trg}, 0);
        end

        // R13 write and transfer in the same cycle
        cfg(0, 1, 0, 1, 0, 0, 0);
        @(negedge clk);
        wr_en = 1; wr_addr = 0; wr_data = 16'hBEEF; master_upd = 1;
        @(negedge clk);
        wr_en = 0; master_upd = 0;
        @(negedge clk);
        chk(active_flat[15:0] == 16'hBEEF, "R13", 64'(active_flat[15:0]), 64'hBEEF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule